// File: doc/BRIEF.md
# Mixed-Width True Dual-Port RAM

This block is a synchronous memory with two fully independent access ports, A and B. Each port can read and write. Both ports view one shared storage array built from 9-bit lanes. Each lane holds eight data bits and one extra bit. Each port picks its own data width from 1, 2, 4, 9, 18 or 36 bits. A 36-bit port can therefore deposit a word that a 4-bit port later picks apart nibble by nibble, or the other way round. Addresses count data bits, so a wider port ignores the low address bits that fall inside its own word.

Each port has a write-mode parameter. The mode chooses what the port's registered read output shows in a cycle in which that port writes:
- the value it held before, or
- the freshly stored word, or
- the contents the location had before the write.

Each read output also has:
- a clock-enable-qualified synchronous reset to a per-port constant, and
- a start-up value loaded by the block reset.

The array itself comes up preloaded with a computed pattern. Both ports are rising-edge synchronous to one clock, and each port has its own clock enable.

Top module: `tdpram_mw`

## Requirements
- R1: Storage is an array of 9-bit lanes. Bit 8 of each lane is the extra bit and bits 7:0 are data. A port of 9, 18 or 36 bits writes lane k of its word (bits 9k+8:9k) only when its lane-enable bit k is 1. A port of 1, 2 or 4 bits has one enable bit and touches only data bits 7:0 of one lane.
- R2: A port of L lanes (L = width/9) covers lanes (addr>>(3+log2 L))·L through that value plus L−1. Lane 0 sits at the least significant end of its word. A port of width w<9 reads lane addr>>3 at bit offset addr[2:0] rounded down to a multiple of w. Address bits below these positions have no effect.
- R3: With the enable high, no write and no output reset, the read output after a rising edge equals the addressed contents as they stood just before that edge.
- R4: In mode NO_CHANGE, a write cycle leaves that port's read output unchanged.
- R5: In mode WRITE_FIRST, a write cycle puts the stored word after the write on that port's output. Enabled lanes carry the new data and disabled lanes carry the old contents.
- R6: In mode READ_FIRST, a write cycle puts the pre-write contents on that port's output. The other port reading an overlapping location in the same cycle also receives the pre-write contents.
- R7: With a port's enable low, that port changes no memory and its read output holds, whatever its write enables and output reset show.
- R8: With the enable high and the output reset high, the read output takes the port's reset constant on the next edge. A write requested in that cycle is still stored.
- R9: While rst_n is low at a rising edge, each read output loads its initial constant. Memory contents are not altered.
- R10: At start-up, lane i holds (37·i + MEM_SEED) mod 512.
- R11: Writes from both ports in one cycle to different lanes are both stored. Writes to overlapping bits leave those bits undefined.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock shared by both ports |
| rst_n | input | 1 | Synchronous active-low reset of the read outputs |
| a_en | input | 1 | Port A clock enable |
| a_we | input | max(1, WIDTH_A/9) | Port A lane write enables |
| a_addr | input | ADDR_W | Port A data-bit address |
| a_wdata | input | WIDTH_A | Port A write data |
| a_orst | input | 1 | Port A read-output reset (qualified by a_en) |
| a_rdata | output | WIDTH_A | Port A registered read data |
| b_en | input | 1 | Port B clock enable |
| b_we | input | max(1, WIDTH_B/9) | Port B lane write enables |
| b_addr | input | ADDR_W | Port B data-bit address |
| b_wdata | input | WIDTH_B | Port B write data |
| b_orst | input | 1 | Port B read-output reset (qualified by b_en) |
| b_rdata | output | WIDTH_B | Port B registered read data |

## Verification
Every read-output effect is due exactly one rising edge after the cycle that presents it. A stored write becomes visible to either port's read one edge after the write edge. The bench changes inputs on the falling edge and computes each port's expected output from a lane-level model. It samples at the following falling edge, after that model has been updated in the order the block stores: port A first, then port B. Two instances cover all three write modes. Random traffic avoids same-cycle overlapping writes, and directed cases hit the cross-port read-before-write, the ignored low address bits, idle-enable holds and a mid-run reset that must spare the memory.

// File: rtl/tdpram_pkg.sv
// Shared definitions for the mixed-width dual-port RAM.
// Assumes storage lanes of 9 bits, 8 of them data bits.
package tdpram_pkg;

    localparam int LANE_W    = 9;
    localparam int DATA_BITS = 8;

    // Per-port behaviour of the read output during a write
    typedef enum logic [1:0] {
        WM_NO_CHANGE   = 2'd0,
        WM_WRITE_FIRST = 2'd1,
        WM_READ_FIRST  = 2'd2
    } wmode_e;

    // Number of 9-bit lanes a port of the given width spans
    function automatic int lanes_of(input int width);
        return (width < LANE_W) ? 1 : width / LANE_W;
    endfunction

    // Start-up content of lane idx
    function automatic logic [LANE_W-1:0] init_lane(input int idx, input logic [LANE_W-1:0] seed);
        return LANE_W'((idx * 37 + int'(seed)) % 512);
    endfunction

endpackage

// File: rtl/tdpram_addr_map.sv
// Converts a data-bit address into a lane index and a bit offset for one port.
// Assumes WIDTH is one of 1, 2, 4, 9, 18, 36. Wide ports get an aligned lane index
// and offset 0. Narrow ports get the lane holding the bit and an offset rounded down
// to the port width.
module tdpram_addr_map #(
    parameter int ADDR_W = 11,
    parameter int WIDTH  = 36,
    localparam int IDX_W = ADDR_W - 3
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [IDX_W-1:0]  lane_idx,
    output logic [2:0]        bit_off
);
    localparam int LANES = tdpram_pkg::lanes_of(WIDTH);
    localparam int LG    = $clog2(LANES);

    generate
        if (WIDTH < tdpram_pkg::LANE_W) begin : g_narrow
            // Narrow port: one lane, aligned offset inside its data bits
            always_comb begin
                lane_idx = addr[ADDR_W-1:3];
                bit_off  = addr[2:0] & ~3'(WIDTH - 1);
            end
        end else if (LG == 0) begin : g_one_lane
            // Single-lane port: offset bits ignored
            always_comb begin
                lane_idx = addr[ADDR_W-1:3];
                bit_off  = 3'd0;
            end
        end else begin : g_multi_lane
            // Multi-lane port: lane index aligned to the lane count
            always_comb begin
                lane_idx = {addr[ADDR_W-1:3+LG], {LG{1'b0}}};
                bit_off  = 3'd0;
            end
        end
    endgenerate

endmodule

// File: rtl/tdpram_lane_io.sv
// Per-port data path between the lane window and the port data.
// Takes the lanes the port currently addresses and produces the old word, the word
// after this port's write, the updated lane window and the lanes to be stored.
// Assumes the window is pre-write memory content.
module tdpram_lane_io #(
    parameter int WIDTH = 36,
    localparam int LANES = tdpram_pkg::lanes_of(WIDTH),
    localparam int WIN_W = LANES * tdpram_pkg::LANE_W
) (
    input  logic [WIN_W-1:0] win,
    input  logic [2:0]       bit_off,
    input  logic [LANES-1:0] we,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] old_word,
    output logic [WIDTH-1:0] new_word,
    output logic [WIN_W-1:0] win_next,
    output logic [LANES-1:0] lane_wr
);
    generate
        if (WIDTH < tdpram_pkg::LANE_W) begin : g_narrow
            // Narrow access: select and patch a slice of the data bits
            always_comb begin
                old_word = win[bit_off +: WIDTH];
                new_word = we[0] ? wdata : old_word;
                win_next = win;
                if (we[0]) win_next[bit_off +: WIDTH] = wdata;
                lane_wr  = we;
            end
        end else begin : g_wide
            // Wide access: merge write data lane by lane
            always_comb begin
                old_word = win;
                for (int k = 0; k < LANES; k++) begin
                    new_word[k*tdpram_pkg::LANE_W +: tdpram_pkg::LANE_W] = we[k] ?
                        wdata[k*tdpram_pkg::LANE_W +: tdpram_pkg::LANE_W] :
                        win[k*tdpram_pkg::LANE_W +: tdpram_pkg::LANE_W];
                end
                win_next = new_word;
                lane_wr  = we;
            end
        end
    endgenerate

endmodule

// File: rtl/tdpram_out_reg.sv
// Registered read output of one port.
// Handles the start-up value, the enable-qualified output reset and the write mode.
// Assumes old_word and new_word are valid in the cycle being clocked.
module tdpram_out_reg #(
    parameter int                 WIDTH = 36,
    parameter tdpram_pkg::wmode_e MODE  = tdpram_pkg::WM_READ_FIRST,
    parameter logic [WIDTH-1:0]   INIT  = '0,
    parameter logic [WIDTH-1:0]   RSTV  = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             orst,
    input  logic             wr,
    input  logic [WIDTH-1:0] old_word,
    input  logic [WIDTH-1:0] new_word,
    output logic [WIDTH-1:0] rdata
);
    // Output register: reset, enable gating, then write-mode selection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= INIT;
        end else if (en) begin
            if (orst) begin
                rdata <= RSTV;
            end else if (!wr) begin
                rdata <= old_word;
            end else begin
                case (MODE)
                    tdpram_pkg::WM_NO_CHANGE:   rdata <= rdata;
                    tdpram_pkg::WM_WRITE_FIRST: rdata <= new_word;
                    default:                    rdata <= old_word;
                endcase
            end
        end
    end

endmodule

// File: rtl/tdpram_mw.sv
// Mixed-width true dual-port RAM over shared 9-bit-lane storage.
// Both ports are synchronous to clk. Port A's write is applied before port B's,
// so overlapping same-cycle writes are undefined from the user's view.
// Assumes WIDTH_A and WIDTH_B are in {1,2,4,9,18,36} and ADDR_W >= 9.
module tdpram_mw #(
    parameter int                   ADDR_W   = 11,
    parameter int                   WIDTH_A  = 36,
    parameter int                   WIDTH_B  = 4,
    parameter tdpram_pkg::wmode_e   MODE_A   = tdpram_pkg::WM_READ_FIRST,
    parameter tdpram_pkg::wmode_e   MODE_B   = tdpram_pkg::WM_WRITE_FIRST,
    parameter logic [WIDTH_A-1:0]   INIT_A   = '0,
    parameter logic [WIDTH_B-1:0]   INIT_B   = '0,
    parameter logic [WIDTH_A-1:0]   RST_A    = '0,
    parameter logic [WIDTH_B-1:0]   RST_B    = '0,
    parameter logic [8:0]           MEM_SEED = 9'h05A
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   a_en,
    input  logic [tdpram_pkg::lanes_of(WIDTH_A)-1:0] a_we,
    input  logic [ADDR_W-1:0]                      a_addr,
    input  logic [WIDTH_A-1:0]                     a_wdata,
    input  logic                                   a_orst,
    output logic [WIDTH_A-1:0]                     a_rdata,
    input  logic                                   b_en,
    input  logic [tdpram_pkg::lanes_of(WIDTH_B)-1:0] b_we,
    input  logic [ADDR_W-1:0]                      b_addr,
    input  logic [WIDTH_B-1:0]                     b_wdata,
    input  logic                                   b_orst,
    output logic [WIDTH_B-1:0]                     b_rdata
);
    localparam int LW      = tdpram_pkg::LANE_W;
    localparam int IDX_W   = ADDR_W - 3;
    localparam int NLANES  = 2 ** IDX_W;
    localparam int LANES_A = tdpram_pkg::lanes_of(WIDTH_A);
    localparam int LANES_B = tdpram_pkg::lanes_of(WIDTH_B);

    logic [LW-1:0] mem [NLANES];

    logic [IDX_W-1:0]      a_idx, b_idx;
    logic [2:0]            a_off, b_off;
    logic [LANES_A*LW-1:0] a_win, a_win_next;
    logic [LANES_B*LW-1:0] b_win, b_win_next;
    logic [WIDTH_A-1:0]    a_old, a_new;
    logic [WIDTH_B-1:0]    b_old, b_new;
    logic [LANES_A-1:0]    a_lane_wr;
    logic [LANES_B-1:0]    b_lane_wr;

    // Start-up content of the storage array
    initial begin
        for (int i = 0; i < NLANES; i++) mem[i] = tdpram_pkg::init_lane(i, MEM_SEED);
    end

    tdpram_addr_map #(.ADDR_W(ADDR_W), .WIDTH(WIDTH_A)) u_map_a (
        .addr(a_addr), .lane_idx(a_idx), .bit_off(a_off));
    tdpram_addr_map #(.ADDR_W(ADDR_W), .WIDTH(WIDTH_B)) u_map_b (
        .addr(b_addr), .lane_idx(b_idx), .bit_off(b_off));

    genvar k;
    generate
        for (k = 0; k < LANES_A; k++) begin : g_win_a
            assign a_win[k*LW +: LW] = mem[a_idx + IDX_W'(k)];
        end
        for (k = 0; k < LANES_B; k++) begin : g_win_b
            assign b_win[k*LW +: LW] = mem[b_idx + IDX_W'(k)];
        end
    endgenerate

    tdpram_lane_io #(.WIDTH(WIDTH_A)) u_io_a (
        .win(a_win), .bit_off(a_off), .we(a_we), .wdata(a_wdata),
        .old_word(a_old), .new_word(a_new), .win_next(a_win_next), .lane_wr(a_lane_wr));
    tdpram_lane_io #(.WIDTH(WIDTH_B)) u_io_b (
        .win(b_win), .bit_off(b_off), .we(b_we), .wdata(b_wdata),
        .old_word(b_old), .new_word(b_new), .win_next(b_win_next), .lane_wr(b_lane_wr));

    // Storage update: port A lanes first, then port B lanes
    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES_A; i++) begin
            if (a_en && a_lane_wr[i]) mem[a_idx + IDX_W'(i)] <= a_win_next[i*LW +: LW];
        end
        for (int i = 0; i < LANES_B; i++) begin
            if (b_en && b_lane_wr[i]) mem[b_idx + IDX_W'(i)] <= b_win_next[i*LW +: LW];
        end
    end

    tdpram_out_reg #(.WIDTH(WIDTH_A), .MODE(MODE_A), .INIT(INIT_A), .RSTV(RST_A)) u_out_a (
        .clk(clk), .rst_n(rst_n), .en(a_en), .orst(a_orst), .wr(|a_we),
        .old_word(a_old), .new_word(a_new), .rdata(a_rdata));
    tdpram_out_reg #(.WIDTH(WIDTH_B), .MODE(MODE_B), .INIT(INIT_B), .RSTV(RST_B)) u_out_b (
        .clk(clk), .rst_n(rst_n), .en(b_en), .orst(b_orst), .wr(|b_we),
        .old_word(b_old), .new_word(b_new), .rdata(b_rdata));

endmodule

// File: rtl/tdpram_mw_chk.sv
// Port-level temporal checks for tdpram_mw, bound into every instance.
// Assumes the parameters passed match those of the bound instance.
module tdpram_mw_chk #(
    parameter int                 WIDTH_A = 36,
    parameter int                 WIDTH_B = 4,
    parameter tdpram_pkg::wmode_e MODE_A  = tdpram_pkg::WM_READ_FIRST,
    parameter tdpram_pkg::wmode_e MODE_B  = tdpram_pkg::WM_WRITE_FIRST,
    parameter logic [WIDTH_A-1:0] RST_A   = '0,
    parameter logic [WIDTH_B-1:0] RST_B   = '0,
    localparam int LANES_A = tdpram_pkg::lanes_of(WIDTH_A),
    localparam int LANES_B = tdpram_pkg::lanes_of(WIDTH_B)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               a_en,
    input logic [LANES_A-1:0] a_we,
    input logic [WIDTH_A-1:0] a_wdata,
    input logic               a_orst,
    input logic [WIDTH_A-1:0] a_rdata,
    input logic               b_en,
    input logic [LANES_B-1:0] b_we,
    input logic [WIDTH_B-1:0] b_wdata,
    input logic               b_orst,
    input logic [WIDTH_B-1:0] b_rdata
);
    // R7
    a_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !a_en |=> $stable(a_rdata));
    // R7
    b_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !b_en |=> $stable(b_rdata));
    // R8
    a_orst_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (a_en && a_orst) |=> (a_rdata == RST_A));
    // R8
    b_orst_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b_en && b_orst) |=> (b_rdata == RST_B));

    generate
        if (MODE_A == tdpram_pkg::WM_NO_CHANGE) begin : g_a_nc
            // R4
            a_nochange_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (a_en && !a_orst && |a_we) |=> $stable(a_rdata));
        end
        if (MODE_A == tdpram_pkg::WM_WRITE_FIRST) begin : g_a_wf
            // R5
            a_wrfirst_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (a_en && !a_orst && &a_we) |=> (a_rdata == $past(a_wdata)));
        end
        if (MODE_B == tdpram_pkg::WM_NO_CHANGE) begin : g_b_nc
            // R4
            b_nochange_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (b_en && !b_orst && |b_we) |=> $stable(b_rdata));
        end
        if (MODE_B == tdpram_pkg::WM_WRITE_FIRST) begin : g_b_wf
            // R5
            b_wrfirst_echo_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (b_en && !b_orst && &b_we) |=> (b_rdata == $past(b_wdata)));
        end
    endgenerate

endmodule

bind tdpram_mw tdpram_mw_chk #(
    .WIDTH_A(WIDTH_A), .WIDTH_B(WIDTH_B), .MODE_A(MODE_A), .MODE_B(MODE_B),
    .RST_A(RST_A), .RST_B(RST_B)
) u_chk (
    .clk(clk), .rst_n(rst_n),
    .a_en(a_en), .a_we(a_we), .a_wdata(a_wdata), .a_orst(a_orst), .a_rdata(a_rdata),
    .b_en(b_en), .b_we(b_we), .b_wdata(b_wdata), .b_orst(b_orst), .b_rdata(b_rdata)
);

// File: tb/tb_tdpram_mw.sv
`timescale 1ns/1ps
// Bench for tdpram_mw: two instances cover all write modes.
// dut : A 36-bit READ_FIRST, B 4-bit WRITE_FIRST
// dut2: A 9-bit NO_CHANGE,  B 18-bit READ_FIRST
module tb_tdpram_mw;
    localparam logic [35:0] INIT_A = 36'h1_2345_6789;
    localparam logic [35:0] RST_A  = 36'hA_BCDE_F012;
    localparam logic [3:0]  INIT_B = 4'h6;
    localparam logic [3:0]  RST_B  = 4'h9;
    localparam logic [8:0]  INIT_C = 9'h155;
    localparam logic [8:0]  RST_C  = 9'h0F0;
    localparam logic [17:0] INIT_D = 18'h2AAAA;
    localparam logic [17:0] RST_D  = 18'h0F0F0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic a_en = 0, a_orst = 0, b_en = 0, b_orst = 0;
    logic [3:0] a_we = '0;  logic [0:0] b_we = '0;
    logic [10:0] a_addr = '0, b_addr = '0;
    logic [35:0] a_wd = '0, a_rd;  logic [3:0] b_wd = '0, b_rd;
    logic c_en = 0, c_orst = 0, d_en = 0, d_orst = 0;
    logic [0:0] c_we = '0;  logic [1:0] d_we = '0;
    logic [10:0] c_addr = '0, d_addr = '0;
    logic [8:0] c_wd = '0, c_rd;  logic [17:0] d_wd = '0, d_rd;

    tdpram_mw #(.ADDR_W(11), .WIDTH_A(36), .WIDTH_B(4),
        .MODE_A(tdpram_pkg::WM_READ_FIRST), .MODE_B(tdpram_pkg::WM_WRITE_FIRST),
        .INIT_A(INIT_A), .INIT_B(INIT_B), .RST_A(RST_A), .RST_B(RST_B), .MEM_SEED(9'h05A)) dut (
        .clk(clk), .rst_n(rst_n),
        .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wd), .a_orst(a_orst), .a_rdata(a_rd),
        .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wd), .b_orst(b_orst), .b_rdata(b_rd));

    tdpram_mw #(.ADDR_W(11), .WIDTH_A(9), .WIDTH_B(18),
        .MODE_A(tdpram_pkg::WM_NO_CHANGE), .MODE_B(tdpram_pkg::WM_READ_FIRST),
        .INIT_A(INIT_C), .INIT_B(INIT_D), .RST_A(RST_C), .RST_B(RST_D), .MEM_SEED(9'h1C3)) dut2 (
        .clk(clk), .rst_n(rst_n),
        .a_en(c_en), .a_we(c_we), .a_addr(c_addr), .a_wdata(c_wd), .a_orst(c_orst), .a_rdata(c_rd),
        .b_en(d_en), .b_we(d_we), .b_addr(d_addr), .b_wdata(d_wd), .b_orst(d_orst), .b_rdata(d_rd));

    logic [8:0] m1 [256];
    logic [8:0] m2 [256];
    logic [35:0] ea;  logic [3:0] eb;  logic [8:0] ec;  logic [17:0] ed;
    int n_chk = 0, n_err = 0;
    bit done = 0;

    // Model reads per the lane mapping of R2
    function automatic logic [35:0] rd_a(input logic [10:0] ad);
        int b = int'(ad >> 5) * 4;
        return {m1[b+3], m1[b+2], m1[b+1], m1[b]};
    endfunction
    function automatic logic [3:0] rd_b(input logic [10:0] ad);
        logic [8:0] l = m1[int'(ad >> 3)];
        return ad[2] ? l[7:4] : l[3:0];
    endfunction
    function automatic logic [17:0] rd_d(input logic [10:0] ad);
        int b = int'(ad >> 4) * 2;
        return {m2[b+1], m2[b]};
    endfunction

    task automatic chk(input string req, input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock of dut with model update; A READ_FIRST (R6), B WRITE_FIRST (R5)
    task automatic tick1(input string ra, input string rb);
        logic [35:0] oa;  logic [3:0] ob;
        int base, bi;
        oa = rd_a(a_addr);  ob = rd_b(b_addr);
        if (a_en) ea = a_orst ? RST_A : oa;
        if (b_en) eb = b_orst ? RST_B : (b_we[0] ? b_wd : ob);
        base = int'(a_addr >> 5) * 4;
        if (a_en) for (int k = 0; k < 4; k++) if (a_we[k]) m1[base+k] = a_wd[k*9 +: 9];
        bi = int'(b_addr >> 3);
        if (b_en && b_we[0]) begin
            if (b_addr[2]) m1[bi][7:4] = b_wd; else m1[bi][3:0] = b_wd;
        end
        @(posedge clk); @(negedge clk);
        chk(ra, a_rd, ea);
        chk(rb, {32'd0, b_rd}, {32'd0, eb});
    endtask

    // One clock of dut2; C NO_CHANGE (R4), D READ_FIRST (R6)
    task automatic tick2(input string rc, input string rd);
        logic [8:0] oc;  logic [17:0] od;
        int db;
        oc = m2[int'(c_addr >> 3)];  od = rd_d(d_addr);
        if (c_en) begin
            if (c_orst) ec = RST_C; else if (!c_we[0]) ec = oc;
        end
        if (d_en) ed = d_orst ? RST_D : od;
        if (c_en && c_we[0]) m2[int'(c_addr >> 3)] = c_wd;
        db = int'(d_addr >> 4) * 2;
        if (d_en) for (int k = 0; k < 2; k++) if (d_we[k]) m2[db+k] = d_wd[k*9 +: 9];
        @(posedge clk); @(negedge clk);
        chk(rc, {27'd0, c_rd}, {27'd0, ec});
        chk(rd, {18'd0, d_rd}, {18'd0, ed});
    endtask

    task automatic idle_all();
        a_en = 0; a_we = '0; a_orst = 0; b_en = 0; b_we = '0; b_orst = 0;
        c_en = 0; c_we = '0; c_orst = 0; d_en = 0; d_we = '0; d_orst = 0;
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        // R10: start-up content
        for (int i = 0; i < 256; i++) begin
            m1[i] = 9'((i * 37 + 'h5A) % 512);
            m2[i] = 9'((i * 37 + 'h1C3) % 512);
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R9: outputs at start-up value
        chk("R9", a_rd, INIT_A);  chk("R9", {32'd0, b_rd}, {32'd0, INIT_B});
        chk("R9", {27'd0, c_rd}, {27'd0, INIT_C});  chk("R9", {18'd0, d_rd}, {18'd0, INIT_D});
        ea = INIT_A; eb = INIT_B; ec = INIT_C; ed = INIT_D;
        rst_n = 1;

        // R10/R3: read preloaded content through both widths
        a_en = 1; a_addr = 11'd0; b_en = 1; b_addr = 11'd12;
        tick1("R10", "R10");
        // R2: low address bits inside a wide word ignored
        a_addr = 11'd37; b_addr = 11'd15;
        tick1("R2", "R2");
        chk("R2", a_rd, {m1[7], m1[6], m1[5], m1[4]});

        // R6: A writes while B reads a lane of the same word
        a_addr = 11'd64; a_we = 4'hF; a_wd = 36'h1_FE3C_7A55; b_addr = 11'd84; b_we = '0;
        tick1("R6", "R6");
        a_we = '0; tick1("R3", "R3");
        // R1/R5: partial lanes, B writes a nibble
        a_addr = 11'd96; a_we = 4'b0101; a_wd = 36'hF_FFFF_FFFF; b_addr = 11'd132; b_we = 1'b1; b_wd = 4'hC;
        tick1("R1", "R5");
        a_we = '0; b_we = '0; a_addr = 11'd96; b_addr = 11'd108;
        tick1("R1", "R2");
        a_addr = 11'd128; tick1("R5", "R3");

        // R7: enable low ignores write and output reset
        a_en = 0; a_we = 4'hF; a_orst = 1; a_wd = '0; b_en = 0; b_we = 1'b1; b_orst = 1;
        tick1("R7", "R7");
        a_en = 1; a_we = '0; a_orst = 0; b_en = 1; b_we = '0; b_orst = 0;
        tick1("R7", "R7");
        // R8: output reset wins on output, write still stored
        a_orst = 1; a_we = 4'b0011; a_wd = 36'h0_0000_3ABC; b_orst = 1; b_we = 1'b1; b_wd = 4'h3; b_addr = 11'd4;
        tick1("R8", "R8");
        a_orst = 0; a_we = '0; b_orst = 0; b_we = '0;
        tick1("R8", "R8");

        // dut2: R4, R6, R11
        c_en = 1; c_addr = 11'd8; d_en = 1; d_addr = 11'd16;
        tick2("R3", "R3");
        c_we = 1'b1; c_wd = 9'h1A5; d_we = 2'b10; d_wd = 18'h3_3333;
        tick2("R4", "R6");
        c_we = '0; d_we = '0; tick2("R4", "R1");
        c_addr = 11'd16; c_we = 1'b1; c_wd = 9'h0EE; d_addr = 11'd16; d_we = 2'b10; d_wd = 18'h2_5400;
        tick2("R11", "R11");
        c_we = '0; d_we = '0; tick2("R11", "R11");
        c_orst = 1; d_en = 0; d_we = 2'b11; tick2("R8", "R7");
        c_orst = 0; d_en = 1; d_we = '0; tick2("R3", "R7");

        // Random traffic on dut (R3, R5, R6) with overlap avoidance (R11)
        for (int n = 0; n < 3000; n++) begin
            int base, bi;
            a_en = ($urandom % 4) != 0;  a_orst = ($urandom % 16) == 0;
            a_we = ($urandom % 2) ? 4'($urandom) : 4'd0;
            a_addr = 11'($urandom);  a_wd = {4'($urandom), 32'($urandom)};
            b_en = ($urandom % 4) != 0;  b_orst = ($urandom % 16) == 0;
            b_we = 1'($urandom);  b_addr = 11'($urandom);  b_wd = 4'($urandom);
            if (n % 5 == 0) b_addr = {a_addr[10:5], 5'($urandom)};
            base = int'(a_addr >> 5) * 4;  bi = int'(b_addr >> 3);
            if (a_en && b_en && bi >= base && bi < base + 4 && a_we[bi-base]) b_we = '0;
            tick1("R6", "R5");
        end

        // R9: mid-run reset keeps memory
        idle_all();
        rst_n = 0; @(posedge clk); @(negedge clk);
        chk("R9", a_rd, INIT_A);  chk("R9", {18'd0, d_rd}, {18'd0, INIT_D});
        ea = INIT_A; eb = INIT_B; ec = INIT_C; ed = INIT_D;
        rst_n = 1;
        a_en = 1; a_addr = 11'd96; b_en = 1; b_addr = 11'd132;
        tick1("R9", "R9");
        c_en = 1; c_addr = 11'd16; d_en = 1; d_addr = 11'd16;
        tick2("R9", "R9");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule